// File: doc/BRIEF.md
# SDRAM Controller Register Front End with Row-Wrap Address Alias

This block is a register-level model of an SDRAM controller front end. It has three banks of 32-bit registers: a common bank, a control bank and a PHY bank. Software reaches all three over a single-cycle request bus. Every request is accepted, and a read returns its data one cycle later. The block trains nothing and issues no DRAM commands. It stores what software writes, and it answers the PHY-initialisation request by reporting that initialisation has finished at once.

The block also contains an address-remapping stage on the RAM path. A build parameter fixes the installed memory size. When software writes the common geometry register with a row count that does not match that size, the block aliases a 4 KiB window to the first 4 KiB of RAM. The window sits at an offset that depends on the geometry. A size-probing loader that writes at that offset then sees the same data as at the start of RAM, which is the wrap-around that a real, smaller part produces. When the row count matches the installed size, the alias is removed.

Top module: `dram_front_stub`

## Requirements
- R1: After reset, every register in all three banks reads zero and the alias is off, so `ram_addr_o` equals `ram_addr_i`. This includes an address at RAM_BASE + 1 MiB, the alias's parked position.
- R2: A read request (`req_i`=1, `we_i`=0) raises `rvalid_o` with `rdata_o` in the next cycle, and only then. A full write followed by a read of the same word returns the written value. The bank encoding on `win_i` is 0 = common, 1 = control, 2 = PHY, 3 = none, and equal offsets in different banks are distinct words.
- R3: The word index is `addr_i[11:2]`. Indexes of 513 or more in the common bank, 547 or more in the control bank, and 1 or more in the PHY bank are out of range, as is any access with `win_i`=3. Such reads return zero and such writes change nothing. Index 512 (common) and index 546 (control) are still in range.
- R4: Only accesses with `be_i`=4'hF are honoured. Any other `be_i` makes a write change nothing, including any side effect, and makes a read return zero, while `rvalid_o` still follows.
- R5: A full write to control word 0 stores its data there and also sets bit 0 of control words 4 (byte 0x10) and 6 (byte 0x18), keeping their other bits.
- R6: A full write to common word 0 is decoded as follows. The row count is `wdata[7:4]`+1. The bank-address bit count is `wdata[2]`+2. The page size is 2^(`wdata[11:8]`+3) bytes. If SIZE_MIB equals 2^(rows−3), with rows below 3 never matching, the alias is turned off.
- R7: On any other common-word-0 write, if SIZE_MIB is 256, 512 or 1024, the alias is turned on at base RAM_BASE + 2^(log2(SIZE_MIB)+3+banks+log2(page)). A term of 2^ADDR_W or more adds zero.
- R8: With SIZE_MIB = 2048, a non-matching common-word-0 write leaves the alias unchanged, so it is never turned on.
- R9: While the alias is on, an address in [base, base+4096) maps to RAM_BASE + (address − base). Every other address passes through unchanged.
- R10: The alias state changes only in the cycle after the accepting common-word-0 write. `ram_addr_o` in the cycle of the write itself still uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 2 | Register bank select |
| addr_i | input | 12 | Byte offset inside the bank |
| be_i | input | 4 | Byte enables, must be all ones |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| ram_addr_i | input | ADDR_W | RAM-side address before aliasing |
| ram_addr_o | output | ADDR_W | RAM-side address after aliasing |

## Verification
The properties assume that every bus input is a known value from the first clock after reset and that a new request can arrive in every cycle, with no stall. The remap properties also assume that `ram_addr_i` is known in every cycle. The bench drives all inputs on the falling edge and holds each request for exactly one cycle. It keeps `ram_addr_i` at a defined value throughout, and it returns `req_i` to zero between accesses. A second instance built for 2048 MiB shares the same bus, so it sees every geometry write the main instance sees.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_AW    = 12;
  localparam int unsigned IDX_W     = WIN_AW - 2;
  localparam int unsigned NUM_WIN   = 3;

  localparam int unsigned COM_WORDS = 513;
  localparam int unsigned CTL_WORDS = 547;
  localparam int unsigned PHY_WORDS = 1;

  localparam int unsigned CTL_INIT_IDX   = 0;
  localparam int unsigned CTL_STAT_A_IDX = 4;
  localparam int unsigned CTL_STAT_B_IDX = 6;
  localparam int unsigned COM_GEOM_IDX   = 0;

  localparam int unsigned MIR_WIN_LOG2  = 12;
  localparam int unsigned MIR_PARK_LOG2 = 20;

  typedef enum logic [1:0] {
    WIN_COM  = 2'd0,
    WIN_CTL  = 2'd1,
    WIN_PHY  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    MIR_KEEP = 2'd0,
    MIR_OFF  = 2'd1,
    MIR_ON   = 2'd2
  } mir_act_e;

  function automatic int unsigned win_words(int unsigned w);
    case (w)
      0:       return COM_WORDS;
      1:       return CTL_WORDS;
      default: return PHY_WORDS;
    endcase
  endfunction
endpackage

// File: rtl/dfs_reg_window.sv
module dfs_reg_window #(
  parameter int unsigned N_WORDS    = 1,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned DATA_W     = 32,
  parameter bit          HAS_STICKY = 1'b0,
  parameter int unsigned STICKY_A   = 0,
  parameter int unsigned STICKY_B   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sticky_i,
  output logic [DATA_W-1:0] rd_word_o
);
  if (N_WORDS == 1) begin : g_single
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q    <= '0;
      else if (wr_i && idx_i == '0)     q    <= wdata_i;
      else if (HAS_STICKY && sticky_i)  q[0] <= 1'b1;
    end
    assign rd_word_o = q;
  end else begin : g_multi
    localparam int unsigned IW = $clog2(N_WORDS);
    logic [DATA_W-1:0] mem [N_WORDS];
    logic [IW-1:0]     sel;
    assign sel = idx_i[IW-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(N_WORDS); i++) mem[i] <= '0;
      end else begin
        if (HAS_STICKY && sticky_i) begin
          mem[STICKY_A][0] <= 1'b1;
          mem[STICKY_B][0] <= 1'b1;
        end
        if (wr_i) mem[sel] <= wdata_i;
      end
    end
    assign rd_word_o = mem[sel];
  end
endmodule

// File: rtl/dfs_geom_decode.sv
module dfs_geom_decode #(
  parameter int unsigned       SIZE_MIB = 256,
  parameter int unsigned       ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h4000_0000
) (
  input  logic [31:0]         cr_i,
  output dfs_pkg::mir_act_e   act_o,
  output logic [ADDR_W-1:0]   base_o
);
  import dfs_pkg::*;

  localparam int unsigned SIZE_LOG2 = $clog2(SIZE_MIB);
  localparam logic [5:0]  ACT_ROWS  = 6'(SIZE_LOG2 + 3);
  localparam bit          HAS_ACT   = (SIZE_MIB < 2048);
  localparam logic [6:0]  AW_LIM    = 7'(ADDR_W);

  logic [4:0] row_bits;
  logic [1:0] bank_bits;
  logic [4:0] page_log2;
  logic [5:0] span_log2;
  logic       rows_match;
  logic [ADDR_W-1:0] span;

  assign row_bits   = {1'b0, cr_i[7:4]} + 5'd1;
  assign bank_bits  = {1'b0, cr_i[2]} + 2'd2;
  assign page_log2  = {1'b0, cr_i[11:8]} + 5'd3;
  assign rows_match = (row_bits >= 5'd3) && ((row_bits - 5'd3) == 5'(SIZE_LOG2));
  assign span_log2  = ACT_ROWS + {4'b0, bank_bits} + {1'b0, page_log2};
  assign span       = ({1'b0, span_log2} < AW_LIM) ? (ADDR_W'(1) << span_log2) : '0;
  assign base_o     = RAM_BASE + span;

  always_comb begin
    if (rows_match)   act_o = MIR_OFF;
    else if (HAS_ACT) act_o = MIR_ON;
    else              act_o = MIR_KEEP;
  end
endmodule

// File: rtl/dfs_mirror_map.sv
module dfs_mirror_map #(
  parameter int unsigned       ADDR_W    = 40,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 'h4000_0000,
  parameter int unsigned       WIN_LOG2  = 12,
  parameter int unsigned       PARK_LOG2 = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  dfs_pkg::mir_act_e act_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] ram_addr_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              en_o
);
  import dfs_pkg::*;

  localparam logic [ADDR_W-1:0] PARK_BASE = RAM_BASE + (ADDR_W'(1) << PARK_LOG2);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(1) << WIN_LOG2;

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] delta;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= PARK_BASE;
    end else if (upd_i) begin
      case (act_i)
        MIR_OFF: en_q <= 1'b0;
        MIR_ON: begin
          en_q   <= 1'b1;
          base_q <= base_i;
        end
        default: ;
      endcase
    end
  end

  // unsigned difference: addresses below the base wrap high and miss
  assign delta      = ram_addr_i - base_q;
  assign hit        = en_q && (delta < WIN_BYTES);
  assign ram_addr_o = hit ? (RAM_BASE + delta) : ram_addr_i;
  assign en_o       = en_q;
endmodule

// File: rtl/dram_front_stub.sv
module dram_front_stub #(
  parameter int unsigned       SIZE_MIB = 256,
  parameter int unsigned       ADDR_W   = 40,
  parameter logic [ADDR_W-1:0] RAM_BASE = 'h4000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        win_i,
  input  logic [11:0]       addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  input  logic [ADDR_W-1:0] ram_addr_i,
  output logic [ADDR_W-1:0] ram_addr_o
);
  import dfs_pkg::*;

  if (!(SIZE_MIB == 256 || SIZE_MIB == 512 || SIZE_MIB == 1024 || SIZE_MIB == 2048))
  begin : g_bad_size
    $error("SIZE_MIB must be 256, 512, 1024 or 2048");
  end
  if (ADDR_W < 32 || ADDR_W > 63) begin : g_bad_aw
    $error("ADDR_W must lie in 32..63");
  end

  logic [IDX_W-1:0]  idx;
  logic              full_word;
  logic [NUM_WIN-1:0] in_rng;
  logic [NUM_WIN-1:0] wr_en;
  logic [DATA_W-1:0] rd_word [NUM_WIN];
  logic              init_hit;
  logic              com_cr_wr;
  logic [DATA_W-1:0] rd_sel;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  mir_act_e          geom_act;
  logic [ADDR_W-1:0] geom_base;
  logic              mir_en;

  assign idx       = addr_i[WIN_AW-1:2];
  assign full_word = (be_i == 4'hF);
  assign init_hit  = wr_en[WIN_CTL] && (idx == IDX_W'(CTL_INIT_IDX));
  assign com_cr_wr = wr_en[WIN_COM] && (idx == IDX_W'(COM_GEOM_IDX));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int unsigned     N   = win_words(w);
    localparam logic [IDX_W:0]  LIM = (IDX_W+1)'(N);

    assign in_rng[w] = (win_i == 2'(w)) && ({1'b0, idx} < LIM);
    assign wr_en[w]  = req_i && we_i && full_word && in_rng[w];

    dfs_reg_window #(
      .N_WORDS   (N),
      .IDX_W     (IDX_W),
      .DATA_W    (DATA_W),
      .HAS_STICKY(w == int'(WIN_CTL)),
      .STICKY_A  (CTL_STAT_A_IDX),
      .STICKY_B  (CTL_STAT_B_IDX)
    ) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en[w]),
      .idx_i    (idx),
      .wdata_i  (wdata_i),
      .sticky_i ((w == int'(WIN_CTL)) ? init_hit : 1'b0),
      .rd_word_o(rd_word[w])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (in_rng[w]) rd_sel = rd_word[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      rdata_q  <= (req_i && !we_i && full_word) ? rd_sel : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  dfs_geom_decode #(
    .SIZE_MIB(SIZE_MIB),
    .ADDR_W  (ADDR_W),
    .RAM_BASE(RAM_BASE)
  ) u_geom (
    .cr_i  (wdata_i),
    .act_o (geom_act),
    .base_o(geom_base)
  );

  dfs_mirror_map #(
    .ADDR_W   (ADDR_W),
    .RAM_BASE (RAM_BASE),
    .WIN_LOG2 (MIR_WIN_LOG2),
    .PARK_LOG2(MIR_PARK_LOG2)
  ) u_mirror (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (com_cr_wr),
    .act_i     (geom_act),
    .base_i    (geom_base),
    .ram_addr_i(ram_addr_i),
    .ram_addr_o(ram_addr_o),
    .en_o      (mir_en)
  );
endmodule

// File: rtl/dfs_checks.sv
module dfs_checks #(
  parameter int unsigned SIZE_MIB = 256,
  parameter int unsigned ADDR_W   = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        win_i,
  input logic [3:0]        be_i,
  input logic              rvalid_o,
  input logic [31:0]       rdata_o,
  input logic [ADDR_W-1:0] ram_addr_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              mir_en_i,
  input logic              com_cr_wr_i
);
  a_r2_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r2_rvalid_only_for_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  a_r3_no_bank_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && win_i == 2'd3) |=> (rdata_o == 32'd0));

  a_r4_partial_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && be_i != 4'hF) |=> (rdata_o == 32'd0));

  a_r9_pass_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mir_en_i |-> (ram_addr_o == ram_addr_i));

  a_r9_page_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o[11:0] == ram_addr_i[11:0]);

  a_r10_alias_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_cr_wr_i |=> $stable(mir_en_i));

  if (SIZE_MIB == 2048) begin : g_full_size
    a_r8_never_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mir_en_i);
  end
endmodule

bind dram_front_stub dfs_checks #(
  .SIZE_MIB(SIZE_MIB),
  .ADDR_W  (ADDR_W)
) i_dfs_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .win_i      (win_i),
  .be_i       (be_i),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .ram_addr_i (ram_addr_i),
  .ram_addr_o (ram_addr_o),
  .mir_en_i   (mir_en),
  .com_cr_wr_i(com_cr_wr)
);

// File: tb/test_dram_front_stub.sv
module test_dram_front_stub;
  localparam time CLK_PERIOD = 10;
  localparam int unsigned AW = 40;
  localparam logic [AW-1:0] BASE = 40'h40_0000_0000 >> 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    win = 2'd0;
  logic [11:0]   addr = '0;
  logic [3:0]    be = 4'hF;
  logic [31:0]   wdata = '0;
  logic          rvalid, rvalid_2g;
  logic [31:0]   rdata, rdata_2g;
  logic [AW-1:0] ram_in = '0;
  logic [AW-1:0] ram_out, ram_out_2g;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_front_stub #(.SIZE_MIB(256), .ADDR_W(AW), .RAM_BASE(BASE)) i_dram_front_stub (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .win_i(win), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .ram_addr_i(ram_in), .ram_addr_o(ram_out));

  dram_front_stub #(.SIZE_MIB(2048), .ADDR_W(AW), .RAM_BASE(BASE)) i_dram_front_stub_2g (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .win_i(win), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid_2g), .rdata_o(rdata_2g),
    .ram_addr_i(ram_in), .ram_addr_o(ram_out_2g));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pop one expectation per returned read
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected rvalid", 64'(rdata), 64'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, 64'(rdata), 64'(e));
      end
    end
  end

  task automatic wr(input logic [1:0] w, input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b1; win = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic rd(input logic [1:0] w, input logic [11:0] a, input logic [31:0] e,
                    input string tag, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b0; win = w; addr = a; be = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0; be = 4'hF;
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [AW-1:0] e, input string tag);
    ram_in = a;
    #1;
    check(ram_out == e, tag, 64'(ram_out), 64'(e));
  endtask

  // geometry write with remap sampled in the write cycle and the one after
  task automatic geom_wr(input logic [31:0] cr, input logic [AW-1:0] a,
                         input logic [AW-1:0] e_before, input logic [AW-1:0] e_after,
                         input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b1; win = 2'd0; addr = 12'h000; wdata = cr; be = 4'hF;
    probe(a, e_before, {"R10 old mapping in write cycle ", tag});
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    probe(a, e_after, tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, 12'h000, 32'h0, "R1 common word 0 after reset");
    rd(2'd1, 12'h010, 32'h0, "R1 control status A after reset");
    rd(2'd1, 12'h018, 32'h0, "R1 control status B after reset");
    rd(2'd2, 12'h000, 32'h0, "R1 phy word after reset");
    @(negedge clk);
    probe(BASE + 40'h10_0005, BASE + 40'h10_0005, "R1 alias off at park position");

    // R2 store and read back, bank separation
    wr(2'd0, 12'h100, 32'hA5A5_0001);
    wr(2'd1, 12'h100, 32'h0000_1234);
    wr(2'd2, 12'h000, 32'hDEAD_BEEF);
    rd(2'd0, 12'h100, 32'hA5A5_0001, "R2 common readback");
    rd(2'd1, 12'h100, 32'h0000_1234, "R2 control readback same offset");
    rd(2'd2, 12'h000, 32'hDEAD_BEEF, "R2 phy readback");

    // R3 bounds
    wr(2'd0, 12'h800, 32'h0000_0055);
    wr(2'd0, 12'h804, 32'hFFFF_FFFF);
    rd(2'd0, 12'h800, 32'h0000_0055, "R3 last common word kept");
    rd(2'd0, 12'h804, 32'h0, "R3 common past limit reads zero");
    wr(2'd1, 12'h888, 32'h0000_0777);
    wr(2'd1, 12'h88C, 32'h1111_1111);
    rd(2'd1, 12'h888, 32'h0000_0777, "R3 last control word kept");
    rd(2'd1, 12'h88C, 32'h0, "R3 control past limit reads zero");
    wr(2'd2, 12'h004, 32'h2222_2222);
    rd(2'd2, 12'h004, 32'h0, "R3 phy past limit reads zero");
    rd(2'd2, 12'h000, 32'hDEAD_BEEF, "R3 phy word untouched by stray write");
    wr(2'd3, 12'h000, 32'h3333_3333);
    rd(2'd3, 12'h000, 32'h0, "R3 no-bank read zero");
    rd(2'd0, 12'h000, 32'h0, "R3 no-bank write left common word 0");

    // R4 partial accesses
    wr(2'd0, 12'h100, 32'h0, 4'h3);
    rd(2'd0, 12'h100, 32'hA5A5_0001, "R4 partial write ignored");
    rd(2'd0, 12'h100, 32'h0, "R4 partial read zero", 4'h1);
    wr(2'd1, 12'h000, 32'h0000_0099, 4'h3);
    rd(2'd1, 12'h010, 32'h0, "R4 partial init write has no side effect");

    // R5 init handshake
    wr(2'd1, 12'h018, 32'h0000_00F0);
    wr(2'd1, 12'h000, 32'h0000_0042);
    rd(2'd1, 12'h000, 32'h0000_0042, "R5 init value stored");
    rd(2'd1, 12'h010, 32'h0000_0001, "R5 status A bit0 set");
    rd(2'd1, 12'h018, 32'h0000_00F1, "R5 status B bit0 set, rest kept");

    // R7 rows 15, banks 3, page 1024 -> base + 2^24
    geom_wr(32'h0000_07E4, BASE + 40'h100_0123, BASE + 40'h100_0123, BASE + 40'h123,
            "R7 alias on at 2^24");
    probe(BASE + 40'h100_0FFF, BASE + 40'h FFF, "R9 top of window");
    probe(BASE + 40'h100_1000, BASE + 40'h100_1000, "R9 just above window");
    probe(BASE + 40'h0FF_FFFF, BASE + 40'h0FF_FFFF, "R9 just below window");
    check(ram_out_2g == BASE + 40'h0FF_FFFF, "R8 2048 MiB copy passes through",
          64'(ram_out_2g), 64'(BASE + 40'h0FF_FFFF));
    ram_in = BASE + 40'h100_0123;
    #1;
    check(ram_out_2g == BASE + 40'h100_0123, "R8 2048 MiB alias stays off",
          64'(ram_out_2g), 64'(BASE + 40'h100_0123));
    rd(2'd0, 12'h000, 32'h0000_07E4, "R6 geometry word stored");

    // R7 rows 15, banks 2, page 8 -> base + 2^16
    geom_wr(32'h0000_00E0, BASE + 40'h1_0010, BASE + 40'h1_0010, BASE + 40'h10,
            "R7 alias moved to 2^16");
    probe(BASE + 40'h100_0123, BASE + 40'h100_0123, "R9 old window released");

    // R6 rows 11 match 256 MiB -> off
    geom_wr(32'h0000_00A0, BASE + 40'h1_0010, BASE + 40'h10, BASE + 40'h1_0010,
            "R6 alias off on matching rows");

    // R7 corner: rows 1 never match
    geom_wr(32'h0000_0000, BASE + 40'h1_0020, BASE + 40'h1_0020, BASE + 40'h20,
            "R7 alias on for rows below 3");

    drain();

    // R1 reset again mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    probe(BASE + 40'h1_0020, BASE + 40'h1_0020, "R1 alias off after second reset");
    rd(2'd0, 12'h800, 32'h0, "R1 common cleared by reset");
    rd(2'd1, 12'h018, 32'h0, "R1 control cleared by reset");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule